// File: doc/BRIEF.md
# Power-Management Timer with System Control Interrupt

This block keeps a free-running power-management counter and a pair of event registers, status and enable, that together drive a level-sensitive system control interrupt (SCI). A tick-enable input, pulsed at the rate of a 3.579545 MHz reference derived from the platform clock, advances the counter by one. Each time the counter's most significant bit changes, in either direction, a sticky timer-overflow status flag is raised. That flag therefore fires at the half-way point and again at the full wrap. Three further sticky flags capture one-cycle event pulses from a real-time-clock alarm, a power button and a global-lock release.

Software reaches the block through a small register port. It can read the counter, read the status flags and clear them with write-one-to-clear, and read or replace the enable word. The SCI is high whenever any of the four sources is both pending and enabled. Only the low six address bits are decoded, so the register set repeats every 0x40 bytes.

Top module: `pm_timer_sci`

## Requirements
- R1: The counter is CNT_W bits wide (default 24) and is zero after reset. On each clock edge where `tick` is high it increments by one, wrapping to zero after all ones. On edges where `tick` is low it holds its value.
- R2: A read at offset 0x08 returns the counter zero-extended to 32 bits. A write to offset 0x08 changes neither the counter nor any other register.
- R3: The timer-overflow flag, status bit 0, is set on the clock edge after the one at which counter bit CNT_W-1 changed. This holds for both the rise of that bit (for example 0x1FF to 0x200 when CNT_W is 10) and its fall at the wrap (0x3FF to 0x000).
- R4: Status bits are sticky. A write to offset 0x00 clears each implemented status bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A one-cycle pulse on `evt_rtc`, `evt_pwr` or `evt_gbl` sets status bit 10, 8 or 5 respectively on that clock edge. A set request wins over a write-one-to-clear of the same bit on the same edge.
- R6: A write to offset 0x02 replaces all 16 bits of the enable word. A read at offset 0x02 returns that word in bits 15:0, with the upper bits zero.
- R7: `sci` is high exactly when status and enable share a set bit among bits 0, 5, 8 and 10, and low otherwise.
- R8: Only `addr[5:0]` is decoded. An address plus any multiple of 0x40 reaches the same register. Reads of undecoded offsets return zero.
- R9: If a change of counter bit CNT_W-1 is detected on the same edge as a write clearing status bit 0, bit 0 stays set.
- R10: After reset the status flags, the enable word and the counter are zero, and `sci` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable, one cycle per reference tick |
| evt_rtc | input | 1 | Real-time-clock alarm event pulse |
| evt_pwr | input | 1 | Power-button event pulse |
| evt_gbl | input | 1 | Global-lock release event pulse |
| addr | input | ADDR_W | Register byte address, low 6 bits decoded |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data for the status and enable registers |
| rd_data | output | 32 | Combinational read data for `addr` |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The bench builds the block with CNT_W = 10 and ADDR_W = 8. A 10-bit counter changes its top bit every 512 ticks, so both the half-way rise and the full-wrap fall of that bit, and a clear that lands on the same edge as the detection, are reached many times within a short run. Two spare address bits let aliased accesses at +0x40 and +0x80 be driven, which shows that only the low six bits are decoded.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int RD_W  = 32;
    localparam int REG_W = 16;
    localparam int DEC_W = 6;

    localparam logic [DEC_W-1:0] OFF_STS = 6'h00;
    localparam logic [DEC_W-1:0] OFF_EN  = 6'h02;
    localparam logic [DEC_W-1:0] OFF_TMR = 6'h08;

    localparam int POS_TMR = 0;
    localparam int POS_GBL = 5;
    localparam int POS_PWR = 8;
    localparam int POS_RTC = 10;

    localparam logic [REG_W-1:0] SRC_MASK =
        (REG_W'(1) << POS_TMR) | (REG_W'(1) << POS_GBL) |
        (REG_W'(1) << POS_PWR) | (REG_W'(1) << POS_RTC);

    typedef struct packed {
        logic rtc;
        logic pwr;
        logic gbl;
        logic tmr;
    } pm_evt_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STS,
        SEL_EN,
        SEL_TMR
    } reg_sel_e;

    function automatic pm_evt_t evt_from_word(input logic [REG_W-1:0] w);
        pm_evt_t e;
        e.rtc = w[POS_RTC];
        e.pwr = w[POS_PWR];
        e.gbl = w[POS_GBL];
        e.tmr = w[POS_TMR];
        return e;
    endfunction

    function automatic logic [REG_W-1:0] evt_to_word(input pm_evt_t e);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_RTC] = e.rtc;
        w[POS_PWR] = e.pwr;
        w[POS_GBL] = e.gbl;
        w[POS_TMR] = e.tmr;
        return w;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [DEC_W-1:0] a);
        case (a)
            OFF_STS: return SEL_STS;
            OFF_EN:  return SEL_EN;
            OFF_TMR: return SEL_TMR;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             msb_flip
);
    localparam int               MSB = CNT_W - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic ref_msb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            ref_msb_q <= 1'b0;
        end else begin
            if (tick) begin
                cnt_q <= cnt_q + ONE;
            end
            ref_msb_q <= cnt_q[MSB];
        end
    end

    // Top bit differs from the value it held one update earlier.
    assign msb_flip = cnt_q[MSB] ^ ref_msb_q;

endmodule

// File: rtl/pmt_status.sv
module pmt_status
    import pmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pm_evt_t set_req,
    input  pm_evt_t clr_req,
    output pm_evt_t sts_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            // Set requests override a same-edge clear.
            sts_q <= pm_evt_t'((sts_q & ~clr_req) | set_req);
        end
    end

endmodule

// File: rtl/pmt_regif.sv
module pmt_regif
    import pmt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  cnt_q,
    input  pm_evt_t           sts_q,
    output pm_evt_t           clr_req,
    output logic [REG_W-1:0]  en_q,
    output logic [RD_W-1:0]   rd_data
);
    reg_sel_e sel;
    logic     unused_addr_hi;

    assign sel            = decode_offset(addr[DEC_W-1:0]);
    assign unused_addr_hi = ^addr;

    assign clr_req = (wr_en && sel == SEL_STS) ? evt_from_word(wr_data) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en && sel == SEL_EN) begin
            en_q <= wr_data;
        end
    end

    always_comb begin
        case (sel)
            SEL_STS: rd_data = RD_W'(evt_to_word(sts_q));
            SEL_EN:  rd_data = RD_W'(en_q);
            SEL_TMR: rd_data = RD_W'(cnt_q);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pm_timer_sci.sv
module pm_timer_sci
    import pmt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              evt_rtc,
    input  logic              evt_pwr,
    input  logic              evt_gbl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              sci
);
    logic [CNT_W-1:0] cnt_q;
    logic             msb_flip;
    pm_evt_t          set_req;
    pm_evt_t          clr_req;
    pm_evt_t          sts_q;
    logic [REG_W-1:0] en_q;

    pmt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt_q    (cnt_q),
        .msb_flip (msb_flip)
    );

    always_comb begin
        set_req.rtc = evt_rtc;
        set_req.pwr = evt_pwr;
        set_req.gbl = evt_gbl;
        set_req.tmr = msb_flip;
    end

    pmt_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .clr_req (clr_req),
        .sts_q   (sts_q)
    );

    pmt_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt_q   (cnt_q),
        .sts_q   (sts_q),
        .clr_req (clr_req),
        .en_q    (en_q),
        .rd_data (rd_data)
    );

    assign sci = |(evt_to_word(sts_q) & en_q & SRC_MASK);

endmodule

// File: rtl/pmt_checker.sv
module pmt_checker
    import pmt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              evt_rtc,
    input logic              evt_gbl,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [15:0]       wr_data,
    input logic              sci,
    input logic [CNT_W-1:0]  cnt_q,
    input pm_evt_t           sts_q,
    input logic [15:0]       en_q
);
    localparam int MSB = CNT_W - 1;

    logic wr_sts;
    logic wr_enr;
    assign wr_sts = wr_en && (addr[5:0] == 6'h00);
    assign wr_enr = wr_en && (addr[5:0] == 6'h02);

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[MSB] != $past(cnt_q[MSB])) |=> sts_q.tmr);

    p_w1c_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && wr_data[10] && !evt_rtc) |=> !sts_q.rtc);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_q.pwr && !(wr_sts && wr_data[8])) |=> sts_q.pwr);

    p_evt_set_r5: assert property (@(posedge clk) disable iff (rst)
        evt_gbl |=> sts_q.gbl);

    p_en_load_r6: assert property (@(posedge clk) disable iff (rst)
        wr_enr |=> en_q == $past(wr_data));

    p_sci_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (en_q == 16'h0000) |-> !sci);

endmodule

bind pm_timer_sci pmt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_checker (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .evt_rtc (evt_rtc),
    .evt_gbl (evt_gbl),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sci     (sci),
    .cnt_q   (cnt_q),
    .sts_q   (sts_q),
    .en_q    (en_q)
);

// File: tb/pm_timer_sci_bench.sv
module pm_timer_sci_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int ADDR_W     = 8;
    localparam int MSB        = CNT_W - 1;
    localparam logic [15:0] MASK = 16'h0521;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              evt_rtc = 1'b0;
    logic              evt_pwr = 1'b0;
    logic              evt_gbl = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              sci;

    pm_timer_sci #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_pm_timer_sci (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .evt_rtc (evt_rtc),
        .evt_pwr (evt_pwr),
        .evt_gbl (evt_gbl),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .sci     (sci)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;

    logic [CNT_W-1:0] m_cnt = '0;
    logic             m_ref = 1'b0;
    logic [15:0]      m_sts = '0;
    logic [15:0]      m_en  = '0;

    function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a);
        case (a[5:0])
            6'h00:   return {16'h0, m_sts};
            6'h02:   return {16'h0, m_en};
            6'h08:   return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_sci();
        return |(m_sts & m_en & MASK);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic r, input logic p, input logic g,
                         input logic [ADDR_W-1:0] a, input logic we, input logic [15:0] wd);
        tick = t; evt_rtc = r; evt_pwr = p; evt_gbl = g;
        addr = a; wr_en = we; wr_data = wd;
    endtask

    // One clock: update the model for this edge, then compare at the falling edge.
    task automatic step(input string req);
        logic        flip;
        logic [15:0] setv;
        logic [15:0] clrv;
        @(posedge clk);
        flip  = m_cnt[MSB] ^ m_ref;
        m_ref = m_cnt[MSB];
        if (tick) m_cnt = m_cnt + 1'b1;
        setv = {5'b0, evt_rtc, 1'b0, evt_pwr, 2'b0, evt_gbl, 4'b0, flip};
        clrv = (wr_en && addr[5:0] == 6'h00) ? (wr_data & MASK) : 16'h0;
        m_sts = (m_sts & ~clrv) | setv;
        if (wr_en && addr[5:0] == 6'h02) m_en = wr_data;
        @(negedge clk);
        check(rd_data == exp_rd(addr), req, "rd_data", rd_data, exp_rd(addr));
        check(sci == exp_sci(), req, "sci", 32'(sci), 32'(exp_sci()));
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
        drive(1'b0, 1'b0, 1'b0, 1'b0, a, 1'b0, 16'h0);
        #1;
        check(rd_data == exp, req, "read", rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        peek(8'h00, 32'h0, "R10");
        peek(8'h02, 32'h0, "R10");
        peek(8'h08, 32'h0, "R10");
        check(sci == 1'b0, "R10", "sci", 32'(sci), 32'h0);

        // R1: count with gaps
        for (int i = 0; i < 5; i++) begin drive(1, 0, 0, 0, 8'h08, 0, 0); step("R1"); end
        for (int i = 0; i < 3; i++) begin drive(0, 0, 0, 0, 8'h08, 0, 0); step("R1"); end
        check(rd_data == 32'd5, "R1", "count", rd_data, 32'd5);

        // R6: enable load and replace
        drive(0, 0, 0, 0, 8'h02, 1, 16'hFFFF); step("R6");
        check(rd_data == 32'h0000FFFF, "R6", "enable", rd_data, 32'h0000FFFF);
        drive(0, 0, 0, 0, 8'h02, 1, 16'h0121); step("R6");
        check(rd_data == 32'h00000121, "R6", "enable", rd_data, 32'h00000121);

        // R5: event pulse and set-over-clear
        drive(0, 1, 0, 0, 8'h00, 0, 0); step("R5");
        check(rd_data == 32'h0400, "R5", "rtc bit10", rd_data, 32'h0400);
        check(sci == 1'b0, "R7", "sci masked", 32'(sci), 32'h0);
        drive(0, 0, 1, 0, 8'h00, 1, 16'h0100); step("R5");
        check(rd_data == 32'h0500, "R5", "pwr set wins", rd_data, 32'h0500);
        check(sci == 1'b1, "R7", "sci pwr", 32'(sci), 32'h1);
        drive(0, 0, 0, 1, 8'h00, 0, 0); step("R5");
        check(rd_data == 32'h0520, "R5", "gbl bit5", rd_data, 32'h0520);

        // R4: selective write-one-to-clear
        drive(0, 0, 0, 0, 8'h00, 1, 16'h0120); step("R4");
        check(rd_data == 32'h0400, "R4", "w1c", rd_data, 32'h0400);
        check(sci == 1'b0, "R7", "sci low", 32'(sci), 32'h0);

        // R7: enabling a pending source raises sci
        drive(0, 0, 0, 0, 8'h02, 1, 16'h0400); step("R7");
        check(sci == 1'b1, "R7", "sci rtc", 32'(sci), 32'h1);

        // R8: aliases at +0x40
        drive(0, 0, 0, 0, 8'h42, 1, 16'h0000); step("R8");
        check(sci == 1'b0, "R8", "alias enable write", 32'(sci), 32'h0);
        peek(8'h48, 32'd5, "R8");
        peek(8'hC8, 32'd5, "R8");
        peek(8'h04, 32'h0, "R8");

        // R2: timer is read-only
        drive(0, 0, 0, 0, 8'h08, 1, 16'hFFFF); step("R2");
        check(rd_data == 32'd5, "R2", "timer write ignored", rd_data, 32'd5);
        peek(8'h00, 32'h0400, "R2");

        // R3: rise of the top bit
        drive(0, 0, 0, 0, 8'h00, 1, 16'hFFFF); step("R3");
        drive(0, 0, 0, 0, 8'h02, 1, 16'h0001); step("R3");
        while (m_cnt != {1'b0, {(CNT_W-1){1'b1}}}) begin drive(1, 0, 0, 0, 8'h08, 0, 0); step("R3"); end
        drive(1, 0, 0, 0, 8'h00, 0, 0); step("R3");
        check(rd_data == 32'h0, "R3", "not yet set", rd_data, 32'h0);
        drive(0, 0, 0, 0, 8'h00, 0, 0); step("R3");
        check(rd_data == 32'h1, "R3", "set on rise", rd_data, 32'h1);
        check(sci == 1'b1, "R7", "sci tmr", 32'(sci), 32'h1);

        // R3: fall of the top bit at wrap
        drive(0, 0, 0, 0, 8'h00, 1, 16'h0001); step("R3");
        while (m_cnt != {CNT_W{1'b1}}) begin drive(1, 0, 0, 0, 8'h08, 0, 0); step("R3"); end
        drive(1, 0, 0, 0, 8'h08, 0, 0); step("R3");
        check(rd_data == 32'h0, "R3", "wrapped", rd_data, 32'h0);
        drive(0, 0, 0, 0, 8'h00, 0, 0); step("R3");
        check(rd_data == 32'h1, "R3", "set on wrap", rd_data, 32'h1);

        // R9: clear on the detecting edge keeps the flag
        while (m_cnt != {1'b0, {(CNT_W-1){1'b1}}}) begin drive(1, 0, 0, 0, 8'h08, 0, 0); step("R9"); end
        drive(1, 0, 0, 0, 8'h00, 0, 0); step("R9");
        drive(0, 0, 0, 0, 8'h00, 1, 16'h0001); step("R9");
        check(rd_data == 32'h1, "R9", "clear lost to flip", rd_data, 32'h1);
        drive(0, 0, 0, 0, 8'h00, 1, 16'h0001); step("R4");
        check(rd_data == 32'h0, "R4", "later clear", rd_data, 32'h0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic [ADDR_W-1:0] a;
            r = $urandom;
            case (r[14:12])
                3'd0: a = 8'h00; 3'd1: a = 8'h02; 3'd2: a = 8'h08; 3'd3: a = 8'h0C;
                3'd4: a = 8'h40; 3'd5: a = 8'h42; 3'd6: a = 8'h48; default: a = 8'h81;
            endcase
            drive(r[1:0] != 2'b00, r[18:16] == 3'd0, r[21:19] == 3'd0, r[24:22] == 3'd0,
                  a, r[5:3] == 3'd0, 16'($urandom));
            step("R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule